// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block steers a CPU core clock through a retune of its primary PLL. The core selects between exactly two sources: the primary PLL and an alternate clock. A request is either a *before-change* phase or an *after-change* phase. Each request carries three rates: the present rate, the target rate and the alternate-source rate. In the before-change phase the sequencer moves the core onto the alternate source. If the alternate source runs faster than the present rate, it slows it with a safety divider. In the after-change phase it looks the target rate up in a table of auxiliary divider settings. It then issues those settings either before or after the return to the primary source, depending on whether the rate is going up or down.

Requests enter on a valid/ready pair. `req_ready` is high only while the sequencer is idle, so a request offered while a phase is running is held off and not taken. Register writes leave on a second valid/ready pair. While `wr_valid` is high and `wr_ready` is low, the address, data and mask hold still, and the write counts as issued only on the cycle both are high. Each phase ends with a one-cycle `done` pulse, and `err` qualifies that pulse. The core control register has a mux bit (bit `MUX_BIT`, 1 = alternate, 0 = primary) and a divider field `DIV_W` bits wide at `DIV_SHIFT`. `wr_mask` marks the bits a write changes. With the defaults, the core register is at address 0x04, the mux bit is bit 7 and the divider field is bits 4:0, so the divider maximum is 31.

Top module: `cpuclk_seq`

## Requirements
- R1: Before-change phase with alt rate > present rate: exactly one write to address 0x04. Its data has bit 7 set and divider field = ceil(alt/present) − 1, and its mask is 0x9F, so the mux and the divider change together.
- R2: A safety divider above the field maximum (31) is written as 31.
- R3: Before-change phase with alt rate ≤ present rate: exactly one write to 0x04 with data 0x80 and mask 0x80, leaving the divider field untouched.
- R4: After-change phase whose target rate matches no table key: `done` with `err` = 1 and no write at all.
- R5: After-change phase with target > present: the matched entry's auxiliary writes come first, in slot order, then the switch-back write.
- R6: After-change phase with target < present: the switch-back write comes first, then the auxiliary writes in slot order.
- R7: The switch-back is one write to 0x04 with data 0x00 and mask 0x9F. It selects the primary source and clears the divider at once. A table slot whose address is 0 is skipped, and an auxiliary write uses mask 0xFFFFFFFF.
- R8: After-change phase with target = present and a matching key: only the switch-back write is issued.
- R9: After reset, `req_ready` = 1, `wr_valid` = 0 and `done` = 0. `req_ready` stays low from acceptance until the phase ends, so a request offered meanwhile is not taken. `done` lasts one cycle, and in the before-change phase it follows acceptance of the write.
- R10: While `wr_valid` = 1 and `wr_ready` = 0, the write holds valid with unchanged address, data and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid (idle) |
| req_post | input | 1 | 0 = before-change phase, 1 = after-change phase |
| req_old_rate | input | RATE_W | Present core rate |
| req_new_rate | input | RATE_W | Target rate |
| req_alt_rate | input | RATE_W | Alternate-source rate |
| done | output | 1 | One-cycle end-of-phase pulse |
| err | output | 1 | Phase failed (qualifies done) |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write taken |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_mask | output | DW | Bits changed by the write |
| tbl_rate | input | NENT*RATE_W | Table keys, entry i at bits i*RATE_W |
| tbl_addr | input | NENT*NWR*AW | Auxiliary write addresses, entry i slot j at (i*NWR+j)*AW |
| tbl_data | input | NENT*NWR*DW | Auxiliary write data, same layout |

## Verification
Two functions can collide in one cycle: a write held back by `wr_ready`, and a fresh request offered on the request port. The bench stalls the write port in the middle of the auxiliary writes of an upward change and offers a second request for several cycles during the stall. It judges the result by the held write staying valid and unchanged, by `req_ready` staying low, and by the final write log matching the upward-change order exactly, with nothing from the second request. The same kind of collision is repeated while the safety divider is still iterating.

// File: rtl/cpuclk_seq_pkg.sv
package cpuclk_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_DIV  = 3'd1,
    S_PRE  = 3'd2,
    S_LOOK = 3'd3,
    S_AUX  = 3'd4,
    S_BACK = 3'd5,
    S_END  = 3'd6
  } seq_state_e;

endpackage

// File: rtl/cpuclk_ceil_div.sv
// Iterative restoring divider returning ceil(num / den), one quotient bit per cycle.
module cpuclk_ceil_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W:0]   quo
);
  localparam int QW = W + 1;
  localparam int CW = $clog2(QW + 1);

  logic [QW:0]   rem;
  logic [QW-1:0] q;
  logic [W-1:0]  den_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [QW:0]   shifted;
  logic          fits;

  assign shifted = {rem[QW-1:0], q[QW-1]};
  assign fits    = shifted >= {2'b00, den_r};
  assign quo     = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      q     <= '0;
      den_r <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q     <= {1'b0, num} + {1'b0, den} - QW'(1);
        den_r <= den;
        rem   <= '0;
        cnt   <= CW'(QW);
        run   <= 1'b1;
      end else if (run) begin
        rem <= fits ? (shifted - {2'b00, den_r}) : shifted;
        q   <= {q[QW-2:0], fits};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpuclk_rate_lut.sv
// Exact-match search of the rate keys; the lowest matching entry wins.
module cpuclk_rate_lut #(
  parameter int NENT   = 8,
  parameter int RATE_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [NENT*RATE_W-1:0] keys,
  input  logic [RATE_W-1:0]      rate,
  output logic                   hit,
  output logic [IDX_W-1:0]       idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (keys[i*RATE_W +: RATE_W] == rate) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cpuclk_seq.sv
module cpuclk_seq
  import cpuclk_seq_pkg::*;
#(
  parameter int RATE_W    = 32,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int NENT      = 8,
  parameter int NWR       = 4,
  parameter int DIV_W     = 5,
  parameter int DIV_SHIFT = 0,
  parameter int MUX_BIT   = 7,
  parameter int CORE_ADDR = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_post,
  input  logic [RATE_W-1:0]        req_old_rate,
  input  logic [RATE_W-1:0]        req_new_rate,
  input  logic [RATE_W-1:0]        req_alt_rate,
  output logic                     done,
  output logic                     err,
  output logic                     wr_valid,
  input  logic                     wr_ready,
  output logic [AW-1:0]            wr_addr,
  output logic [DW-1:0]            wr_data,
  output logic [DW-1:0]            wr_mask,
  input  logic [NENT*RATE_W-1:0]   tbl_rate,
  input  logic [NENT*NWR*AW-1:0]   tbl_addr,
  input  logic [NENT*NWR*DW-1:0]   tbl_data
);
  localparam int IDX_W   = (NENT > 1) ? $clog2(NENT) : 1;
  localparam int SLOT_W  = (NWR > 1) ? $clog2(NWR) : 1;
  localparam int DIV_MAX = (1 << DIV_W) - 1;
  localparam logic [DW-1:0] MUX_MASK = DW'(1) << MUX_BIT;
  localparam logic [DW-1:0] DIV_MASK = DW'(DIV_MAX) << DIV_SHIFT;

  seq_state_e         st;
  logic [RATE_W-1:0]  old_r, new_r;
  logic               up_r, down_r, err_r, fast_r, back_issued;
  logic [DIV_W-1:0]   div_r, div_calc;
  logic [IDX_W-1:0]   idx_r, lut_idx;
  logic [SLOT_W-1:0]  slot_r;
  logic               lut_hit, div_start, div_done, accept;
  logic [RATE_W:0]    quo, quo_m1;
  logic [AW-1:0]      aux_addr;
  logic [DW-1:0]      aux_data;
  int unsigned        sel;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign div_start = accept && !req_post && (req_alt_rate > req_old_rate);
  assign done      = (st == S_END);
  assign err       = err_r;

  cpuclk_ceil_div #(.W(RATE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (req_alt_rate),
    .den   (req_old_rate),
    .done  (div_done),
    .quo   (quo)
  );

  cpuclk_rate_lut #(.NENT(NENT), .RATE_W(RATE_W), .IDX_W(IDX_W)) u_lut (
    .keys (tbl_rate),
    .rate (new_r),
    .hit  (lut_hit),
    .idx  (lut_idx)
  );

  // Safety divider: quotient minus one, limited to the field maximum.
  assign quo_m1   = (quo == '0) ? '0 : quo - (RATE_W+1)'(1);
  assign div_calc = (quo_m1 > (RATE_W+1)'(DIV_MAX)) ? DIV_W'(DIV_MAX) : quo_m1[DIV_W-1:0];

  assign sel      = int'(idx_r) * NWR + int'(slot_r);
  assign aux_addr = tbl_addr[sel*AW +: AW];
  assign aux_data = tbl_data[sel*DW +: DW];

  always_comb begin
    wr_valid = 1'b0;
    wr_addr  = AW'(CORE_ADDR);
    wr_data  = '0;
    wr_mask  = '0;
    case (st)
      S_PRE: begin
        wr_valid = 1'b1;
        wr_data  = MUX_MASK | (fast_r ? (DW'(div_r) << DIV_SHIFT) : '0);
        wr_mask  = MUX_MASK | (fast_r ? DIV_MASK : '0);
      end
      S_BACK: begin
        wr_valid = 1'b1;
        wr_mask  = MUX_MASK | DIV_MASK;
      end
      S_AUX: begin
        wr_valid = (aux_addr != '0);
        wr_addr  = aux_addr;
        wr_data  = aux_data;
        wr_mask  = '1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      old_r       <= '0;
      new_r       <= '0;
      up_r        <= 1'b0;
      down_r      <= 1'b0;
      err_r       <= 1'b0;
      fast_r      <= 1'b0;
      back_issued <= 1'b0;
      div_r       <= '0;
      idx_r       <= '0;
      slot_r      <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          old_r       <= req_old_rate;
          new_r       <= req_new_rate;
          up_r        <= req_new_rate > req_old_rate;
          down_r      <= req_new_rate < req_old_rate;
          err_r       <= 1'b0;
          back_issued <= 1'b0;
          slot_r      <= '0;
          fast_r      <= req_alt_rate > req_old_rate;
          if (req_post)                          st <= S_LOOK;
          else if (req_alt_rate > req_old_rate)  st <= S_DIV;
          else                                   st <= S_PRE;
        end
        S_DIV: if (div_done) begin
          div_r <= div_calc;
          st    <= S_PRE;
        end
        S_PRE: if (wr_ready) st <= S_END;
        S_LOOK: begin
          if (!lut_hit) begin
            err_r <= 1'b1;
            st    <= S_END;
          end else begin
            idx_r <= lut_idx;
            st    <= up_r ? S_AUX : S_BACK;
          end
        end
        S_AUX: if ((aux_addr == '0) || wr_ready) begin
          if (slot_r == SLOT_W'(NWR - 1)) st <= up_r ? S_BACK : S_END;
          else                            slot_r <= slot_r + SLOT_W'(1);
        end
        S_BACK: if (wr_ready) begin
          back_issued <= 1'b1;
          st          <= down_r ? S_AUX : S_END;
        end
        S_END:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PRE_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE && wr_valid) |-> (wr_addr == AW'(CORE_ADDR)) && wr_data[MUX_BIT] && wr_mask[MUX_BIT]); // R1
  AST_SAFE_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE && fast_r) |-> (((wr_data & DIV_MASK) >> DIV_SHIFT) != '0)); // R2
  AST_SLOW_KEEPS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE && !fast_r) |-> ((wr_mask & DIV_MASK) == '0)); // R3
  AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && !lut_hit) |=> !wr_valid && done && err); // R4
  AST_UP_AUX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AUX && up_r) |-> !back_issued); // R5
  AST_DOWN_AUX_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AUX && down_r) |-> back_issued); // R6
  AST_BACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BACK) |-> (wr_data == '0) && ((wr_mask & (MUX_MASK | DIV_MASK)) == (MUX_MASK | DIV_MASK))); // R7
  AST_PRE_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && !up_r && !down_r && back_issued == 1'b0 && fast_r) |-> $past(wr_valid && wr_ready)); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_mask)); // R10

endmodule

// File: tb/test_cpuclk_seq.sv
`timescale 1ns/1ps
module test_cpuclk_seq;
  localparam int RATE_W = 32, AW = 8, DW = 32, NENT = 8, NWR = 4;
  localparam logic [7:0]  CORE = 8'h04;
  localparam logic [31:0] MUXM = 32'h80, DIVM = 32'h1F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_post = 1'b0, wr_ready = 1'b1;
  logic [RATE_W-1:0] req_old_rate = '0, req_new_rate = '0, req_alt_rate = '0;
  logic req_ready, done, err, wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, wr_mask;
  logic [NENT*RATE_W-1:0] tbl_rate;
  logic [NENT*NWR*AW-1:0] tbl_addr;
  logic [NENT*NWR*DW-1:0] tbl_data;

  always #2.5 clk = ~clk;

  cpuclk_seq i_cpuclk_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_post(req_post), .req_old_rate(req_old_rate), .req_new_rate(req_new_rate),
    .req_alt_rate(req_alt_rate), .done(done), .err(err), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .tbl_rate(tbl_rate), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
  );

  int checks = 0, fails = 0;
  int unsigned bk [NENT];
  logic [7:0]  ba [NENT][NWR];
  logic [31:0] bd [NENT][NWR];

  logic [7:0]  lg_a [32];
  logic [31:0] lg_d [32], lg_m [32];
  int nlog = 0;
  logic [7:0]  ex_a [8];
  logic [31:0] ex_d [8], ex_m [8];
  int ex_n;
  bit ex_err;

  localparam int NV = 9;
  localparam bit          V_POST [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1};
  localparam int unsigned V_OLD  [NV] = '{600, 200, 10, 800, 600, 200, 600, 300, 400};
  localparam int unsigned V_NEW  [NV] = '{0, 0, 0, 0, 0, 600, 300, 450, 400};
  localparam int unsigned V_ALT  [NV] = '{800, 800, 800, 600, 600, 0, 0, 0, 0};
  localparam string       V_REQ  [NV] = '{"R1", "R1", "R2", "R3", "R3", "R5", "R6", "R4", "R8"};

  always @(negedge clk) begin
    if (wr_valid && wr_ready && nlog < 32) begin
      lg_a[nlog] = wr_addr; lg_d[nlog] = wr_data; lg_m[nlog] = wr_mask;
      nlog = nlog + 1;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic add_exp(input logic [7:0] a, input logic [31:0] d, input logic [31:0] m);
    ex_a[ex_n] = a; ex_d[ex_n] = d; ex_m[ex_n] = m; ex_n++;
  endtask

  task automatic add_aux(input int e);
    for (int j = 0; j < NWR; j++)
      if (ba[e][j] != 0) add_exp(ba[e][j], bd[e][j], 32'hFFFF_FFFF);
  endtask

  task automatic build_exp(input bit post, input int unsigned o, input int unsigned n,
                           input int unsigned a);
    longint q;
    int e;
    ex_n = 0; ex_err = 0;
    if (!post) begin
      if (a > o) begin
        q = (longint'(a) + o - 1) / o - 1;
        if (q > 31) q = 31;
        add_exp(CORE, MUXM | 32'(q), MUXM | DIVM);
      end else add_exp(CORE, MUXM, MUXM);
    end else begin
      e = -1;
      for (int i = NENT - 1; i >= 0; i--) if (bk[i] == n) e = i;
      if (e < 0) ex_err = 1;
      else begin
        if (n > o) add_aux(e);
        add_exp(CORE, 32'h0, MUXM | DIVM);
        if (n < o) add_aux(e);
      end
    end
  endtask

  task automatic send(input bit post, input int unsigned o, input int unsigned n,
                      input int unsigned a);
    @(posedge clk); #1;
    req_valid = 1; req_post = post; req_old_rate = o; req_new_rate = n; req_alt_rate = a;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_done(input string rq, output bit e);
    bit seen = 0;
    e = 0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (done) begin seen = 1; e = err; end
    end
    check(seen, rq, "done seen", seen, 1);
    @(negedge clk);
    check(!done, "R9", "done one cycle", done, 0);
  endtask

  task automatic compare(input string rq, input bit e);
    check(e == ex_err, rq, "err flag", e, ex_err);
    check(nlog == ex_n, rq, "write count", nlog, ex_n);
    for (int i = 0; i < ex_n && i < nlog; i++) begin
      check(lg_a[i] == ex_a[i], rq, $sformatf("addr of write %0d", i), lg_a[i], ex_a[i]);
      check(lg_d[i] == ex_d[i], rq, $sformatf("data of write %0d", i), lg_d[i], ex_d[i]);
      check(lg_m[i] == ex_m[i], rq, $sformatf("mask of write %0d", i), lg_m[i], ex_m[i]);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit e;
    logic [7:0] held_a;
    logic [31:0] held_d;
    for (int i = 0; i < NENT; i++) begin
      bk[i] = 100 * (i + 1);
      tbl_rate[i*RATE_W +: RATE_W] = bk[i];
      for (int j = 0; j < NWR; j++) begin
        ba[i][j] = (j == 2 && i[0]) ? 8'h00 : 8'(8'h10 + 4 * j);
        bd[i][j] = 32'hA000_0000 | (i << 8) | j;
        tbl_addr[(i*NWR+j)*AW +: AW] = ba[i][j];
        tbl_data[(i*NWR+j)*DW +: DW] = bd[i][j];
      end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R9", "reset req_ready", req_ready, 1);
    check(wr_valid == 0, "R9", "reset wr_valid", wr_valid, 0);
    check(done == 0, "R9", "reset done", done, 0);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      nlog = 0;
      build_exp(V_POST[v], V_OLD[v], V_NEW[v], V_ALT[v]);
      send(V_POST[v], V_OLD[v], V_NEW[v], V_ALT[v]);
      wait_done(V_REQ[v], e);
      compare(V_REQ[v], e);
    end

    // busy while the divider iterates: second request not taken (R9, R2)
    nlog = 0;
    build_exp(0, 1, 0, 1000);
    send(0, 1, 0, 1000);
    #1; req_valid = 1; req_post = 1; req_old_rate = 200; req_new_rate = 300;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(req_ready == 0, "R9", "busy req_ready", req_ready, 0);
    end
    @(posedge clk); #1; req_valid = 0;
    wait_done("R9", e);
    compare("R2", e);

    // stalled write collides with a fresh request (R10, R9, R5)
    nlog = 0;
    wr_ready = 0;
    build_exp(1, 200, 500, 0);
    send(1, 200, 500, 0);
    @(negedge clk); @(negedge clk);
    check(wr_valid == 1, "R10", "stalled write valid", wr_valid, 1);
    held_a = wr_addr; held_d = wr_data;
    @(posedge clk); #1;
    req_valid = 1; req_post = 0; req_old_rate = 100; req_alt_rate = 900;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(wr_valid == 1 && wr_addr == held_a && wr_data == held_d, "R10",
            "write held under stall", {wr_addr, wr_data}, {held_a, held_d});
      check(req_ready == 0, "R9", "request held off", req_ready, 0);
    end
    @(posedge clk); #1; req_valid = 0; wr_ready = 1;
    wait_done("R5", e);
    compare("R5", e);
    repeat (5) @(negedge clk);
    check(nlog == ex_n, "R9", "no write from refused request", nlog, ex_n);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule